// File: doc/BRIEF.md
# Hamiltonian Walk Scheduler with Memory

This block chooses, once per time slot, the input-to-output permutation for an N-by-N input-queued switch with one virtual output queue per input/output pair. It does not search for the best match. It keeps the schedule chosen in the previous slot and sets it against a single fresh candidate. That candidate comes from a walk that steps through every one of the N! permutations in turn. Each of the two is scored against the current queue-length matrix. The heavier one becomes the new schedule. This keeps the per-slot cost at two weight sums, one comparison and one constant-time step of the walk.

A slot begins when the surrounding logic pulses `slotStrobe` while presenting the queue-length matrix. The block registers both weights on that edge. On the following edge it commits the winner, advances the walk and pulses `schedValid`. Any strobe that arrives during that second cycle is dropped. The walk steps by swapping two neighbouring entries each slot, using a direction per element. From the last permutation of a period, one final neighbour swap returns it to the identity.

Top module: `hws_sched`

## Requirements
- R1: While reset is asserted and right after it is released, both `sched` and `cand` hold the identity permutation (input i maps to output i), and `schedValid` is low.
- R2: `sched` and `cand` are always permutations. Field i (bits i*IW upward, IW = ceil(log2 N)) holds the output for input i, and every output value appears exactly once.
- R3: Each time the walk advances, the new `cand` differs from the previous one in exactly two neighbouring fields, which have been swapped.
- R4: Over any N! consecutive slots starting from reset, `cand` shows every permutation exactly once and is back at the identity after N! slots.
- R5: A permutation's weight is the saturating sum over inputs i of the queue length in `qLen` at bits (i*N + j)*QW upward, where j is the output that input i is given. `schedWeight` reports the weight of the chosen schedule.
- R6: The candidate replaces the stored schedule only if its weight is strictly larger. On a tie or a smaller weight, the previous schedule is kept.
- R7: A strobe sampled while the block is idle produces a single-cycle `schedValid` pulse, together with the new `sched`, `schedWeight` and `cand`, at the second rising edge counted from the sampling edge.
- R8: A strobe sampled during the commit cycle is ignored. It produces no extra result, and the walk advances only once.
- R9: The reported weight is never below the previous schedule's weight evaluated on the same queue lengths.
- R10: `sched` and `cand` do not change except on the cycle in which `schedValid` is raised.
- R11: Weights use the queue lengths present at the sampling edge. Changes to `qLen` after that edge do not alter the slot's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotStrobe | input | 1 | Starts a slot evaluation when sampled high while idle |
| qLen | input | N*N*QW | Queue-length matrix, entry (i,j) at bits (i*N+j)*QW |
| sched | output | N*IW | Chosen schedule, output index for input i at bits i*IW |
| cand | output | N*IW | Walk permutation the next slot will evaluate |
| schedWeight | output | QW+ceil(log2 N) | Weight of the chosen schedule for the last slot |
| schedValid | output | 1 | One-cycle pulse when a new schedule is committed |

## Verification
The bench builds the block with N = 4 and QW = 8. This makes the walk period 24 slots, so the bench can run two and a half full periods. It records every candidate in a 256-entry table indexed by the packed permutation, which proves the no-repeat property and the return to identity directly. Six queue-length patterns rotate through the slots: all-zero, all-equal, all-maximum, a single heavy diagonal and two arithmetic mixes. Together they produce candidate wins, strict losses and ties, and they reach the largest possible weight of 1020. Every slot also raises a second strobe during the commit cycle and inverts the queue lengths after the sampling edge.

// File: rtl/hws_pkg.sv
package hws_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;  // latch both candidate weights
    logic commit;   // pick the winner and advance the walk
  } hwsCtl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EVAL = 1'b1
  } hwsState_t;

endpackage

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    slotStrobe,
  output hwsCtl_t ctl
);

  hwsState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (slotStrobe) stateNext = ST_EVAL;
      ST_EVAL: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // A strobe seen during the commit cycle is dropped
  assign ctl.capture = (state == ST_IDLE) && slotStrobe;
  assign ctl.commit  = (state == ST_EVAL);

endmodule

// File: rtl/hws_weigh.sv
module hws_weigh #(
  parameter int N  = 4,
  parameter int QW = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1,
  parameter int WW = QW + IW
) (
  input  logic [N*N*QW-1:0] qLen,
  input  logic [N*IW-1:0]   perm,
  output logic [WW-1:0]     weight
);

  logic [QW-1:0] qArr    [N][N];
  logic [IW-1:0] permArr [N];

  for (genvar gi = 0; gi < N; gi++) begin : gRow
    assign permArr[gi] = perm[gi*IW +: IW];
    for (genvar gj = 0; gj < N; gj++) begin : gCol
      assign qArr[gi][gj] = qLen[(gi*N + gj)*QW +: QW];
    end
  end

  function automatic logic [WW-1:0] satAdd(input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [WW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[WW] ? {WW{1'b1}} : s[WW-1:0];
  endfunction

  always_comb begin
    logic [WW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      acc = satAdd(acc, WW'(qArr[i][permArr[i]]));
    end
    weight = acc;
  end

endmodule

// File: rtl/hws_walk.sv
module hws_walk #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          advance,
  output logic [N*IW-1:0] permFlat
);

  // Value at each position and its travel direction (1 = toward higher index)
  logic [IW-1:0] permR    [N];
  logic [IW-1:0] permNext [N];
  logic [N-1:0]  dirR, dirNext;

  logic [N-1:0]  rLess, lLess, mobile;
  logic [IW-1:0] sPerm [N];
  logic [N-1:0]  sDir;

  logic          found;
  logic          bestRight;
  logic [IW-1:0] bestPos;
  logic [IW-1:0] bestVal;
  logic [N-2:0]  swapSel;  // bit p: swap positions p and p+1

  // Mobility of each element: its neighbour in its direction is smaller
  for (genvar g = 0; g < N; g++) begin : gMob
    if (g < N-1) begin : gR
      assign rLess[g] = permR[g+1] < permR[g];
    end else begin : gRn
      assign rLess[g] = 1'b0;
    end
    if (g > 0) begin : gL
      assign lLess[g] = permR[g-1] < permR[g];
    end else begin : gLn
      assign lLess[g] = 1'b0;
    end
    assign mobile[g] = dirR[g] ? rLess[g] : lLess[g];
  end

  // Largest mobile element
  always_comb begin
    found     = 1'b0;
    bestRight = 1'b0;
    bestPos   = '0;
    bestVal   = '0;
    for (int p = 0; p < N; p++) begin
      if (mobile[p] && (!found || permR[p] > bestVal)) begin
        found     = 1'b1;
        bestPos   = IW'(p);
        bestVal   = permR[p];
        bestRight = dirR[p];
      end
    end
  end

  // With no mobile element the walk closes its cycle by swapping the first pair
  always_comb begin
    for (int p = 0; p < N-1; p++) begin
      if (found) begin
        swapSel[p] = (bestRight && bestPos == IW'(p)) ||
                     (!bestRight && bestPos == IW'(p+1));
      end else begin
        swapSel[p] = (p == 0);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : gSwap
    logic [IW-1:0] lVal, rVal;
    logic          lDir, rDir, takeL, takeR;
    if (g > 0) begin : gL
      assign lVal  = permR[g-1];
      assign lDir  = dirR[g-1];
      assign takeL = swapSel[g-1];
    end else begin : gL0
      assign lVal  = permR[g];
      assign lDir  = dirR[g];
      assign takeL = 1'b0;
    end
    if (g < N-1) begin : gR
      assign rVal  = permR[g+1];
      assign rDir  = dirR[g+1];
      assign takeR = swapSel[g];
    end else begin : gR0
      assign rVal  = permR[g];
      assign rDir  = dirR[g];
      assign takeR = 1'b0;
    end
    assign sPerm[g] = takeL ? lVal : (takeR ? rVal : permR[g]);
    assign sDir[g]  = takeL ? lDir : (takeR ? rDir : dirR[g]);

    assign permNext[g] = sPerm[g];
    // Elements larger than the one moved reverse; a wrap restarts all facing low
    assign dirNext[g]  = found ? (sDir[g] ^ (sPerm[g] > bestVal)) : 1'b0;
    assign permFlat[g*IW +: IW] = permR[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < N; g++) permR[g] <= IW'(g);
      dirR <= '0;
    end else if (advance) begin
      permR <= permNext;
      dirR  <= dirNext;
    end
  end

endmodule

// File: rtl/hws_datapath.sv
module hws_datapath
  import hws_pkg::*;
#(
  parameter int N  = 4,
  parameter int QW = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1,
  parameter int WW = QW + IW
) (
  input  logic            clk,
  input  logic            rstN,
  input  hwsCtl_t         ctl,
  input  logic [N*N*QW-1:0] qLen,
  output logic [N*IW-1:0] sched,
  output logic [N*IW-1:0] cand,
  output logic [WW-1:0]   schedWeight,
  output logic            schedValid
);

  localparam int NCAND = 2;  // index 0: stored schedule, index 1: walk candidate

  logic [N*IW-1:0] schedR;
  logic [N*IW-1:0] candFlat;
  logic [N*IW-1:0] evalPerm [NCAND];
  logic [WW-1:0]   evalW    [NCAND];
  logic [WW-1:0]   wLatch   [NCAND];
  logic [WW-1:0]   weightR;
  logic            validR;
  logic            candWins;

  hws_walk #(.N(N), .IW(IW)) u_walk (
    .clk      (clk),
    .rstN     (rstN),
    .advance  (ctl.commit),
    .permFlat (candFlat)
  );

  assign evalPerm[0] = schedR;
  assign evalPerm[1] = candFlat;

  for (genvar k = 0; k < NCAND; k++) begin : gEval
    hws_weigh #(.N(N), .QW(QW), .IW(IW), .WW(WW)) u_weigh (
      .qLen   (qLen),
      .perm   (evalPerm[k]),
      .weight (evalW[k])
    );
  end

  // Strictly heavier wins; ties keep the remembered schedule
  assign candWins = wLatch[1] > wLatch[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < N; g++) schedR[g*IW +: IW] <= IW'(g);
      for (int k = 0; k < NCAND; k++) wLatch[k] <= '0;
      weightR <= '0;
      validR  <= 1'b0;
    end else begin
      validR <= ctl.commit;
      if (ctl.capture) begin
        for (int k = 0; k < NCAND; k++) wLatch[k] <= evalW[k];
      end
      if (ctl.commit) begin
        if (candWins) begin
          schedR  <= candFlat;
          weightR <= wLatch[1];
        end else begin
          weightR <= wLatch[0];
        end
      end
    end
  end

  assign sched       = schedR;
  assign cand        = candFlat;
  assign schedWeight = weightR;
  assign schedValid  = validR;

endmodule

// File: rtl/hws_sched.sv
module hws_sched
  import hws_pkg::*;
#(
  parameter int N  = 4,
  parameter int QW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int WW = QW + IW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotStrobe,
  input  logic [N*N*QW-1:0] qLen,
  output logic [N*IW-1:0]   sched,
  output logic [N*IW-1:0]   cand,
  output logic [WW-1:0]     schedWeight,
  output logic              schedValid
);

  hwsCtl_t ctl;

  hws_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .slotStrobe (slotStrobe),
    .ctl        (ctl)
  );

  hws_datapath #(.N(N), .QW(QW), .IW(IW), .WW(WW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .qLen        (qLen),
    .sched       (sched),
    .cand        (cand),
    .schedWeight (schedWeight),
    .schedValid  (schedValid)
  );

endmodule

// File: rtl/hws_sched_chk.sv
module hws_sched_chk #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            slotStrobe,
  input logic [N*IW-1:0] sched,
  input logic [N*IW-1:0] cand,
  input logic            schedValid
);

  logic            candIsPerm, schedIsPerm;
  logic [N*IW-1:0] candQ;
  logic [N-1:0]    diffMask;

  always_comb begin
    candIsPerm  = 1'b1;
    schedIsPerm = 1'b1;
    for (int v = 0; v < N; v++) begin
      int cc, sc;
      cc = 0;
      sc = 0;
      for (int g = 0; g < N; g++) begin
        if (cand[g*IW +: IW] == IW'(v))  cc++;
        if (sched[g*IW +: IW] == IW'(v)) sc++;
      end
      if (cc != 1) candIsPerm  = 1'b0;
      if (sc != 1) schedIsPerm = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < N; g++) candQ[g*IW +: IW] <= IW'(g);
    end else begin
      candQ <= cand;
    end
  end

  always_comb begin
    for (int g = 0; g < N; g++) diffMask[g] = cand[g*IW +: IW] != candQ[g*IW +: IW];
  end

  // R2
  cand_perm_chk: assert property (@(posedge clk) disable iff (!rstN) candIsPerm);

  // R2
  sched_perm_chk: assert property (@(posedge clk) disable iff (!rstN) schedIsPerm);

  // R3
  walk_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    schedValid |-> ($countones(diffMask) == 2) && ((diffMask & (diffMask >> 1)) != '0));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    schedValid |=> !schedValid);

  // R7
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    schedValid |-> $past(slotStrobe, 2));

  // R10
  sched_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !schedValid |-> $stable(sched));

  // R10
  cand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !schedValid |-> $stable(cand));

endmodule

bind hws_sched hws_sched_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .slotStrobe (slotStrobe),
  .sched      (sched),
  .cand       (cand),
  .schedValid (schedValid)
);

// File: tb/sim_hws_sched.sv
module sim_hws_sched;

  localparam int N          = 4;
  localparam int QW         = 8;
  localparam int IW         = 2;
  localparam int WW         = QW + IW;
  localparam int NFACT      = 24;
  localparam int NSLOTS     = 60;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              slotStrobe = 1'b0;
  logic [N*N*QW-1:0] qLen = '0;
  logic [N*IW-1:0]   sched, cand;
  logic [WW-1:0]     schedWeight;
  logic              schedValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  bit seen [256];
  int qm [N][N];

  always #(CLK_PERIOD/2) clk = ~clk;

  hws_sched #(.N(N), .QW(QW)) u0 (
    .clk         (clk),
    .rstN        (rstN),
    .slotStrobe  (slotStrobe),
    .qLen        (qLen),
    .sched       (sched),
    .cand        (cand),
    .schedWeight (schedWeight),
    .schedValid  (schedValid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int patVal(input int s, input int i, input int j);
    case (s % 6)
      0:       return (i*37 + j*11 + s*3) % 256;
      1:       return 255;
      2:       return 9;
      3:       return (j == (i + s) % N) ? 200 : 1;
      4:       return 0;
      default: return ((i+1)*(j+2)*s + j) % 256;
    endcase
  endfunction

  function automatic int field(input logic [N*IW-1:0] v, input int i);
    return int'(v[i*IW +: IW]);
  endfunction

  function automatic int weightOf(input logic [N*IW-1:0] v);
    int w;
    w = 0;
    for (int i = 0; i < N; i++) w += qm[i][field(v, i)];
    return w;
  endfunction

  function automatic bit adjSwap(input logic [N*IW-1:0] a, input logic [N*IW-1:0] b);
    int cnt, first;
    cnt = 0;
    first = -1;
    for (int i = 0; i < N; i++) begin
      if (field(a, i) != field(b, i)) begin
        if (first < 0) first = i;
        cnt++;
      end
    end
    if (cnt != 2) return 1'b0;
    return (field(a, first) == field(b, first+1)) && (field(a, first+1) == field(b, first));
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, NSLOTS*3);
      summary();
      $finish;
    end
  end

  initial begin
    logic [N*IW-1:0] identV, prevV, candV, lastCand, candAfter, expV;
    int wPrev, wCand, expW, nSeen;

    for (int i = 0; i < N; i++) identV[i*IW +: IW] = IW'(i);
    for (int k = 0; k < 256; k++) seen[k] = 1'b0;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk(sched == identV, "R1", "sched in reset", sched, identV);
    chk(cand == identV, "R1", "cand in reset", cand, identV);
    chk(schedValid == 1'b0, "R1", "valid in reset", schedValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 and R10 after release with no strobe
    chk(sched == identV, "R1", "sched after reset", sched, identV);
    chk(cand == identV, "R1", "cand after reset", cand, identV);
    chk(schedValid == 1'b0, "R10", "no result without strobe", schedValid, 0);

    prevV = identV;
    lastCand = identV;
    for (int s = 0; s < NSLOTS; s++) begin
      candV = cand;
      if (s < NFACT) begin
        // R4 no repeat within a period
        chk(!seen[int'(candV)], "R4", "candidate repeated", candV, -1);
        seen[int'(candV)] = 1'b1;
      end
      if (s % NFACT == 0) chk(candV == identV, "R4", "walk period start", candV, identV);
      if (s > 0) chk(adjSwap(lastCand, candV), "R3", "neighbour swap step", candV, lastCand);
      lastCand = candV;

      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          qm[i][j] = patVal(s, i, j);
          qLen[(i*N + j)*QW +: QW] = QW'(qm[i][j]);
        end
      wPrev = weightOf(prevV);
      wCand = weightOf(candV);
      expV  = (wCand > wPrev) ? candV : prevV;
      expW  = (wCand > wPrev) ? wCand : wPrev;

      slotStrobe = 1'b1;
      @(negedge clk);
      // R11 disturb lengths after sampling; R8 strobe stays high into the commit cycle
      qLen = ~qLen;
      chk(schedValid == 1'b0, "R7", "no result after one edge", schedValid, 0);
      @(negedge clk);
      chk(schedValid == 1'b1, "R7", "result on second edge", schedValid, 1);
      chk(sched == expV, "R6", "chosen schedule", sched, expV);
      chk(schedWeight == WW'(expW), "R5", "chosen weight", schedWeight, expW);
      chk(int'(schedWeight) >= wPrev, "R9", "weight not below previous", schedWeight, wPrev);
      chk(schedWeight == WW'(expW), "R11", "weight from sampled lengths", schedWeight, expW);
      candAfter = cand;
      slotStrobe = 1'b0;
      @(negedge clk);
      chk(schedValid == 1'b0, "R8", "strobe in commit cycle ignored", schedValid, 0);
      chk(cand == candAfter, "R8", "walk advanced once", cand, candAfter);
      chk(sched == expV, "R10", "schedule held", sched, expV);
      prevV = expV;
    end

    nSeen = 0;
    for (int k = 0; k < 256; k++) if (seen[k]) nSeen++;
    chk(nSeen == NFACT, "R4", "distinct permutations in one period", nSeen, NFACT);
    chk(cand != identV, "R2", "walk moved past identity", cand, -1);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule